// File: doc/BRIEF.md
# Gated Singles Histogram Accumulator

This block builds a singles spectrum on chip. Each ADC conversion result is a channel index. For each accepted value the block performs a read-modify-write on that channel's bin and adds one to its count. A host read port returns any bin's count one cycle after the request. Host reads have their own memory port, so they never stall the update sequence.

A run/halt bit enables collection. A card set for combined singles and coincidence operation also follows the shared coincidence command bus. A coincidence event freezes collection until a bus clear pulse arrives, and collection is blocked for as long as the bus request line is high. A card in singles-only mode ignores all bus activity and keeps counting.

Top module: `singles_hist`

## Requirements
- R1: Each ADC value that is accepted while collection is enabled adds exactly one to the bin whose index equals the value. There are 2**ADDR_W bins, each COUNT_W bits wide, and COUNT_W defaults to 32. All bins start at zero.
- R2: A counted value keeps `adc_ready` low for exactly three cycles after its acceptance edge. `adc_ready` is high again after the fourth edge. A value that is held on the input while `adc_ready` is low is only taken on the next edge at which `adc_ready` is high.
- R3: A bin that holds all ones keeps that value on further increments and never wraps to zero.
- R4: A write with `ctl_we` high and `ctl_run_bit` = 1 sets the run state. `ctl_run_bit` = 0 halts collection. After reset the block is halted.
- R5: A value that is accepted while collection is disabled is consumed in one cycle. It changes no bin, and `adc_ready` stays high.
- R6: With `combo_mode` = 1, a `coin_evt` pulse freezes collection from the next cycle onward. The freeze lasts until a `bus_clear` pulse is seen. If both pulses occur in the same cycle, the block stays frozen.
- R7: With `combo_mode` = 1, a value offered while `bus_req` is high is discarded.
- R8: With `combo_mode` = 0, `bus_req`, `bus_clear` and `coin_evt` have no effect, and any pending freeze is dropped. Returning to `combo_mode` = 1 therefore starts unfrozen.
- R9: A host read with `rd_en` high at an edge sets `rd_valid` high after that edge. `rd_data` then holds the count of `rd_addr`.
- R10: A host read of a bin, issued in the cycle in which an update writes that same bin, returns the new count.
- R11: After reset, `adc_ready` is high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Start/stop register write strobe |
| ctl_run_bit | input | 1 | Run (1) or halt (0) value written |
| combo_mode | input | 1 | 1 = combined singles and coincidence, 0 = singles only |
| bus_req | input | 1 | Command-bus data-valid request level |
| bus_clear | input | 1 | Command-bus clear pulse |
| coin_evt | input | 1 | Coincidence event pulse |
| adc_valid | input | 1 | ADC value offered |
| adc_chan | input | ADDR_W | ADC value (bin index) |
| adc_ready | output | 1 | Block can take an ADC value |
| rd_en | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Bin to read |
| rd_data | output | COUNT_W | Count of the requested bin |
| rd_valid | output | 1 | rd_data holds the requested count |

## Verification
A wrong update state shows up within four cycles as an `adc_ready` low window of the wrong length. It can also show as a bin count that differs from the bench's model at the next readback. A bad freeze or request gate shows at the ports as a bin that gained or missed a count, and the readback right after the offered value reveals it. The saturation and forwarding paths each change exactly one readback value. The bench samples that value in the cycle it is produced.

// File: rtl/shist_pkg.sv
package shist_pkg;
  typedef enum logic [1:0] {
    UPD_IDLE  = 2'd0,
    UPD_READ  = 2'd1,
    UPD_ADD   = 2'd2,
    UPD_WRITE = 2'd3
  } upd_state_t;
endpackage

// File: rtl/shist_gate.sv
module shist_gate (
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic ctl_run_bit,
  input  logic combo_mode,
  input  logic bus_req,
  input  logic bus_clear,
  input  logic coin_evt,
  output logic collect_en
);
  logic run_q;
  logic frozen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (ctl_we) begin
      run_q <= ctl_run_bit;
    end
  end

  // Freeze follows coincidence activity only in combined mode; an event wins over a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_q <= 1'b0;
    end else if (!combo_mode) begin
      frozen_q <= 1'b0;
    end else if (coin_evt) begin
      frozen_q <= 1'b1;
    end else if (bus_clear) begin
      frozen_q <= 1'b0;
    end
  end

  always_comb begin
    collect_en = run_q && !(combo_mode && (frozen_q || bus_req));
  end

  assert_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_run_bit) |=> !collect_en);

  assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (combo_mode && coin_evt) ##1 combo_mode |-> !collect_en);

  assert_req_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (combo_mode && bus_req) |-> !collect_en);

  assert_singles_free_R8: assert property (@(posedge clk) disable iff (rst)
    (!combo_mode && ctl_we && ctl_run_bit) ##1 !combo_mode |-> collect_en);
endmodule

// File: rtl/shist_ram.sv
module shist_ram #(
  parameter int ADDR_W  = 8,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               a_re,
  input  logic               a_we,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [COUNT_W-1:0] a_wdata,
  output logic [COUNT_W-1:0] a_q,
  input  logic               b_re,
  input  logic [ADDR_W-1:0]  b_addr,
  output logic [COUNT_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [COUNT_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/shist_update.sv
module shist_update
  import shist_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adc_valid,
  input  logic [ADDR_W-1:0]  adc_chan,
  input  logic               collect_en,
  output logic               adc_ready,
  output logic               ram_re,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  input  logic [COUNT_W-1:0] ram_q,
  output logic [COUNT_W-1:0] ram_wdata
);
  localparam logic [COUNT_W-1:0] FULL = {COUNT_W{1'b1}};

  upd_state_t         st;
  logic [ADDR_W-1:0]  bin_q;
  logic [COUNT_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= UPD_IDLE;
      bin_q <= '0;
      sum_q <= '0;
    end else begin
      case (st)
        UPD_IDLE: if (adc_valid && collect_en) begin
          st    <= UPD_READ;
          bin_q <= adc_chan;
        end
        UPD_READ:  st <= UPD_ADD;
        UPD_ADD: begin
          st    <= UPD_WRITE;
          sum_q <= (ram_q == FULL) ? FULL : ram_q + 1'b1;
        end
        default:   st <= UPD_IDLE;
      endcase
    end
  end

  always_comb begin
    adc_ready = (st == UPD_IDLE);
    ram_re    = (st == UPD_READ);
    ram_we    = (st == UPD_WRITE);
    ram_addr  = bin_q;
    ram_wdata = sum_q;
  end

  assert_busy_three_R2: assert property (@(posedge clk) disable iff (rst)
    (adc_valid && adc_ready && collect_en) |=> !adc_ready ##1 !adc_ready ##1 !adc_ready ##1 adc_ready);

  assert_drop_fast_R5: assert property (@(posedge clk) disable iff (rst)
    (adc_valid && adc_ready && !collect_en) |=> adc_ready);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_wdata != '0);

  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (st == UPD_ADD && ram_q == FULL) |=> ram_wdata == FULL);
endmodule

// File: rtl/singles_hist.sv
module singles_hist #(
  parameter int ADDR_W  = 8,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic               ctl_run_bit,
  input  logic               combo_mode,
  input  logic               bus_req,
  input  logic               bus_clear,
  input  logic               coin_evt,
  input  logic               adc_valid,
  input  logic [ADDR_W-1:0]  adc_chan,
  output logic               adc_ready,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [COUNT_W-1:0] rd_data,
  output logic               rd_valid
);
  logic               collect_en;
  logic               ram_re;
  logic               ram_we;
  logic [ADDR_W-1:0]  ram_addr;
  logic [COUNT_W-1:0] ram_q;
  logic [COUNT_W-1:0] ram_wdata;
  logic [COUNT_W-1:0] host_q;
  logic               fwd_hit;
  logic [COUNT_W-1:0] fwd_data;

  shist_gate u_gate (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_run_bit(ctl_run_bit),
    .combo_mode(combo_mode), .bus_req(bus_req), .bus_clear(bus_clear),
    .coin_evt(coin_evt), .collect_en(collect_en)
  );

  shist_update #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_update (
    .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_chan(adc_chan),
    .collect_en(collect_en), .adc_ready(adc_ready), .ram_re(ram_re),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_q(ram_q), .ram_wdata(ram_wdata)
  );

  shist_ram #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_ram (
    .clk(clk), .a_re(ram_re), .a_we(ram_we), .a_addr(ram_addr),
    .a_wdata(ram_wdata), .a_q(ram_q), .b_re(rd_en), .b_addr(rd_addr), .b_q(host_q)
  );

  // The memory port returns the old word on a same-address collision; bypass with the new count.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      rd_valid <= rd_en;
      fwd_hit  <= rd_en && ram_we && (rd_addr == ram_addr);
      fwd_data <= ram_wdata;
    end
  end

  always_comb begin
    rd_data = fwd_hit ? fwd_data : host_q;
  end

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_collision_new_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ram_we && rd_addr == ram_addr) |=> rd_data == $past(ram_wdata));
endmodule

// File: tb/singles_hist_test.sv
module singles_hist_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int CW = 8;
  localparam int NB = 1 << AW;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NV = 16;
  localparam logic [AW-1:0] VEC [NV] = '{4'd3, 4'd3, 4'd0, 4'd15, 4'd7, 4'd3, 4'd9, 4'd0,
                                         4'd12, 4'd7, 4'd7, 4'd1, 4'd3, 4'd14, 4'd9, 4'd2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 0, ctl_run_bit = 0, combo_mode = 0;
  logic bus_req = 0, bus_clear = 0, coin_evt = 0;
  logic adc_valid = 0;
  logic [AW-1:0] adc_chan = '0;
  logic adc_ready;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int fails = 0;
  int model [NB];
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  singles_hist #(.ADDR_W(AW), .COUNT_W(CW)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_run_bit(ctl_run_bit),
    .combo_mode(combo_mode), .bus_req(bus_req), .bus_clear(bus_clear),
    .coin_evt(coin_evt), .adc_valid(adc_valid), .adc_chan(adc_chan),
    .adc_ready(adc_ready), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_wait();
    @(negedge clk);
    while (!adc_ready) @(negedge clk);
  endtask

  task automatic send(input logic [AW-1:0] c);
    idle_wait();
    adc_valid = 1; adc_chan = c;
    @(negedge clk);
    adc_valid = 0;
  endtask

  task automatic ctl(input logic run);
    @(negedge clk);
    ctl_we = 1; ctl_run_bit = run;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic pulse_coin(input logic with_clear);
    @(negedge clk);
    coin_evt = 1; bus_clear = with_clear;
    @(negedge clk);
    coin_evt = 0; bus_clear = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    bus_clear = 1;
    @(negedge clk);
    bus_clear = 0;
  endtask

  task automatic read_bin(input string req, input logic [AW-1:0] a);
    idle_wait();
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    check(req, int'(rd_valid), 1);
    check(req, int'(rd_data), model[a]);
  endtask

  function automatic void bump(input int c);
    if (model[c] < MAXC) model[c]++;
  endfunction

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: reset state
    check("R11", int'(adc_ready), 1);
    check("R11", int'(rd_valid), 0);
    read_bin("R1", 4'd5);

    // R4: halted after reset, value consumed without counting (R5)
    send(4'd5);
    check("R5", int'(adc_ready), 1);
    read_bin("R4", 4'd5);

    ctl(1'b1);
    // R1 table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      bump(int'(VEC[i]));
    end
    for (int i = 0; i < NB; i++) read_bin("R1", i[AW-1:0]);

    // R2: three-cycle busy window
    send(4'd6); bump(6);
    check("R2", int'(adc_ready), 0);
    @(negedge clk); check("R2", int'(adc_ready), 0);
    @(negedge clk); check("R2", int'(adc_ready), 0);
    @(negedge clk); check("R2", int'(adc_ready), 1);
    // R2: held value taken only when ready
    idle_wait();
    adc_valid = 1; adc_chan = 4'd5;
    repeat (8) @(negedge clk);
    adc_valid = 0;
    bump(5); bump(5);
    read_bin("R2", 4'd5);

    // R10: collision returns new count
    send(4'd11); bump(11);
    @(negedge clk);
    @(negedge clk);
    rd_en = 1; rd_addr = 4'd11;
    @(negedge clk);
    rd_en = 0;
    check("R10", int'(rd_data), model[11]);

    // R4: halt stops counting
    ctl(1'b0);
    send(4'd6);
    read_bin("R4", 4'd6);
    ctl(1'b1);

    // R6: freeze and clear in combined mode
    combo_mode = 1;
    pulse_coin(1'b0);
    send(4'd8);
    read_bin("R6", 4'd8);
    pulse_clear();
    send(4'd8); bump(8);
    read_bin("R6", 4'd8);
    pulse_coin(1'b1);
    send(4'd8);
    read_bin("R6", 4'd8);

    // R8: leaving combined mode drops the freeze
    combo_mode = 0;
    send(4'd8); bump(8);
    read_bin("R8", 4'd8);
    combo_mode = 1;
    send(4'd8); bump(8);
    read_bin("R8", 4'd8);

    // R7: request blocks in combined mode
    bus_req = 1;
    send(4'd10);
    read_bin("R7", 4'd10);
    bus_req = 0;
    send(4'd10); bump(10);
    read_bin("R7", 4'd10);

    // R8: singles mode ignores bus activity
    combo_mode = 0;
    bus_req = 1;
    pulse_coin(1'b0);
    send(4'd10); bump(10);
    read_bin("R8", 4'd10);
    bus_req = 0;

    // R3: saturation at all ones
    for (int i = 0; i < MAXC + 3; i++) begin
      send(4'd13); bump(13);
    end
    read_bin("R3", 4'd13);
    check("R3", model[13], MAXC);

    // R9: idle read port returns to not valid
    @(negedge clk);
    check("R9", int'(rd_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule